// File: doc/BRIEF.md
# IQ DAC Output Formatter

This block sits at the very end of a transmit chain. It takes one complex sample per valid strobe and lays it out for a DAC data port. In parallel format, I and Q leave together on two buses. In interleaved format, they share one bus: the I word goes first with a frame marker raised, and the Q word follows on the next clock.

A half-rate option keeps every other valid sample. It is meant for the case where an upstream stage interpolates by three, so that the overall rate change becomes three halves. A sync input realigns which sample counts as the first one. The block can also convert two's-complement data to offset binary by flipping the sign bit.

For link bring-up, a two-bit mode field can swap the data for a generated pattern: either alternating all-ones and all-zeros words, or an incrementing ramp. Every output is registered, and a sample reaches the port two clocks after it is presented.

Top module: `iq_dac_formatter`

## Requirements
- R1: While reset is asserted and on the first cycles after release, dac_valid, dac_frame, dac_a and dac_b are all zero.
- R2: With cfg_interleave low, a sample kept in cycle c appears in cycle c+2 with I on dac_a, Q on dac_b, dac_valid high and dac_frame low.
- R3: With cfg_interleave high, a sample kept in cycle c gives I on dac_a with dac_frame high in cycle c+2, then Q on dac_a with dac_frame low in cycle c+3; dac_b stays zero and dac_valid is high in both cycles. In this format, input samples must be at least two cycles apart.
- R4: In any cycle that carries no output word, dac_valid and dac_frame are low and both data buses are zero.
- R5: With cfg_dec2 high, only even-indexed valid samples are kept, where indices count valid samples starting at zero after reset or after a sync; odd-indexed samples produce no output.
- R6: in_sync on a valid sample makes that sample index zero. in_sync with in_valid low makes the next valid sample index zero.
- R7: In data mode with cfg_offset_bin high, the most significant bit of both I and Q is inverted on output. All other bits pass unchanged.
- R8: With cfg_test_mode = 2'b01, each kept sample carries the same word on I and Q. The words alternate between all-ones and all-zeros, starting with all-ones on the first kept sample after entering the mode or after a sync.
- R9: With cfg_test_mode = 2'b10, each kept sample carries a ramp value on I and Q. The ramp starts at zero on entering the mode or after a sync, rises by one per kept sample, and wraps at 2^DATA_W.
- R10: With cfg_test_mode = 2'b00 or 2'b11, the input data is passed through. In both pattern modes, in_i, in_q and cfg_offset_bin have no effect on the output words.
- R11: With cfg_dec2 low, every valid input sample is kept and produces output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interleave | input | 1 | 1: I/Q time-multiplexed on dac_a; 0: parallel on dac_a/dac_b |
| cfg_dec2 | input | 1 | 1: keep even-indexed samples only |
| cfg_offset_bin | input | 1 | 1: invert MSB of data words |
| cfg_test_mode | input | 2 | 00/11 data, 01 ones/zeros toggle, 10 ramp |
| in_valid | input | 1 | Input sample strobe |
| in_sync | input | 1 | Resets decimation phase and pattern state |
| in_i | input | DATA_W | In-phase sample, two's complement |
| in_q | input | DATA_W | Quadrature sample, two's complement |
| dac_a | output | DATA_W | I word (parallel) or I-then-Q words (interleaved) |
| dac_b | output | DATA_W | Q word in parallel format, zero otherwise |
| dac_frame | output | 1 | High while dac_a carries an interleaved I word |
| dac_valid | output | 1 | Output word strobe |

## Verification
The bench builds the block with DATA_W = 8. That lets the ramp pattern run through its full range and wrap within a few hundred samples, and it makes the sign-bit flip of offset binary show up on a large share of the random words. The narrow width also leaves every other path unchanged, since no logic depends on the width beyond the bus size. Random valid gaps and sync pulses, including syncs without a valid sample, exercise the decimation phase and the pattern restarts against a cycle-accurate model of the output slots.

// File: rtl/oformat_pkg.sv
package oformat_pkg;

    typedef enum logic [1:0] {
        TPM_DATA     = 2'b00,
        TPM_TOGGLE   = 2'b01,
        TPM_RAMP     = 2'b10,
        TPM_DATA_ALT = 2'b11
    } tpm_e;

    localparam int OUT_LATENCY = 2;

endpackage

// File: rtl/oformat_decim.sv
module oformat_decim (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sync,
    input  logic dec_en,
    output logic keep
);

    typedef struct packed {
        logic phase;
    } dec_t;

    dec_t st_d, st_q;
    logic eff_phase;

    always_comb begin
        st_d      = st_q;
        eff_phase = in_sync ? 1'b0 : st_q.phase;
        keep      = in_valid && (!dec_en || (eff_phase == 1'b0));
        st_d.phase = in_valid ? ~eff_phase : eff_phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_DEC_DROP_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && $past(dec_en) && in_valid && !in_sync && $past(in_valid && keep))
        |-> !keep); // R5

    AST_SYNC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |-> keep); // R6

endmodule

// File: rtl/oformat_pattern.sv
module oformat_pattern
    import oformat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tpm_e              mode,
    input  logic              in_sync,
    input  logic              keep,
    output logic [DATA_W-1:0] word
);

    typedef struct packed {
        logic              tog;
        logic [DATA_W-1:0] cnt;
    } pat_t;

    pat_t st_d, st_q;
    logic              base_tog;
    logic [DATA_W-1:0] base_cnt;

    always_comb begin
        st_d     = st_q;
        base_tog = in_sync ? 1'b0 : st_q.tog;
        base_cnt = in_sync ? '0 : st_q.cnt;
        word     = '0;
        unique case (mode)
            TPM_TOGGLE: begin
                word     = base_tog ? '0 : '1;
                st_d.tog = keep ? ~base_tog : base_tog;
                st_d.cnt = '0;
            end
            TPM_RAMP: begin
                word     = base_cnt;
                st_d.cnt = keep ? base_cnt + 1'b1 : base_cnt;
                st_d.tog = 1'b0;
            end
            default: begin
                st_d.tog = 1'b0;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TPM_TOGGLE && $past(mode == TPM_TOGGLE) && $past(keep) && !in_sync)
        |-> (word == ~$past(word))); // R8

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TPM_RAMP && $past(mode == TPM_RAMP) && $past(keep) && !in_sync)
        |-> (word == $past(word) + 1'b1)); // R9

endmodule

// File: rtl/oformat_serial.sv
module oformat_serial #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              interleave,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_i,
    input  logic [DATA_W-1:0] s_q,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b,
    output logic              dac_frame,
    output logic              dac_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] pend;
        logic              pend_v;
        logic              frame;
        logic              valid;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.a      = '0;
        st_d.b      = '0;
        st_d.frame  = 1'b0;
        st_d.valid  = 1'b0;
        st_d.pend_v = 1'b0;
        if (s_valid) begin
            st_d.valid = 1'b1;
            st_d.a     = s_i;
            if (interleave) begin
                st_d.frame  = 1'b1;
                st_d.pend   = s_q;
                st_d.pend_v = 1'b1;
            end else begin
                st_d.b = s_q;
            end
        end else if (st_q.pend_v) begin
            st_d.valid = 1'b1;
            st_d.a     = st_q.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_a     = st_q.a;
    assign dac_b     = st_q.b;
    assign dac_frame = st_q.frame;
    assign dac_valid = st_q.valid;

    AST_IL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (interleave && dac_frame) |=> (!interleave || (dac_valid && !dac_frame))); // R3

    AST_IL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (interleave && s_valid) |-> !st_q.pend_v); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_valid |-> (dac_a == '0 && dac_b == '0 && !dac_frame)); // R4

endmodule

// File: rtl/iq_dac_formatter.sv
module iq_dac_formatter
    import oformat_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_interleave,
    input  logic              cfg_dec2,
    input  logic              cfg_offset_bin,
    input  logic [1:0]        cfg_test_mode,
    input  logic              in_valid,
    input  logic              in_sync,
    input  logic [DATA_W-1:0] in_i,
    input  logic [DATA_W-1:0] in_q,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b,
    output logic              dac_frame,
    output logic              dac_valid
);

    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] i;
        logic [DATA_W-1:0] q;
    } stg_t;

    stg_t st_d, st_q;
    tpm_e mode;
    logic keep_w;
    logic is_pattern;
    logic [DATA_W-1:0] pat_word;

    assign mode = tpm_e'(cfg_test_mode);

    oformat_decim u_decim (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .dec_en   (cfg_dec2),
        .keep     (keep_w)
    );

    oformat_pattern #(.DATA_W(DATA_W)) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .in_sync (in_sync),
        .keep    (keep_w),
        .word    (pat_word)
    );

    always_comb begin
        is_pattern = (mode == TPM_TOGGLE) || (mode == TPM_RAMP);
        st_d       = '0;
        if (keep_w) begin
            st_d.valid = 1'b1;
            if (is_pattern) begin
                st_d.i = pat_word;
                st_d.q = pat_word;
            end else if (cfg_offset_bin) begin
                st_d.i = in_i ^ MSB_MASK;
                st_d.q = in_q ^ MSB_MASK;
            end else begin
                st_d.i = in_i;
                st_d.q = in_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    oformat_serial #(.DATA_W(DATA_W)) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .interleave (cfg_interleave),
        .s_valid    (st_q.valid),
        .s_i        (st_q.i),
        .s_q        (st_q.q),
        .dac_a      (dac_a),
        .dac_b      (dac_b),
        .dac_frame  (dac_frame),
        .dac_valid  (dac_valid)
    );

    // cycles since reset, saturating, so latency checks never reach into reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    AST_PAR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !cfg_interleave && !$past(cfg_interleave) && !$past(cfg_interleave, 2))
        |-> (dac_valid == $past(keep_w, 2))); // R2

    AST_NODEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && !cfg_interleave && !$past(cfg_dec2, 2) && !$past(cfg_interleave)
         && !$past(cfg_interleave, 2) && $past(in_valid, 2)) |-> dac_valid); // R11

endmodule

// File: tb/iq_dac_formatter_test.sv
`timescale 1ns/1ps
module iq_dac_formatter_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_interleave = 1'b0;
    logic         cfg_dec2 = 1'b0;
    logic         cfg_offset_bin = 1'b0;
    logic [1:0]   cfg_test_mode = 2'b00;
    logic         in_valid = 1'b0;
    logic         in_sync = 1'b0;
    logic [W-1:0] in_i = '0;
    logic [W-1:0] in_q = '0;
    logic [W-1:0] dac_a, dac_b;
    logic         dac_frame, dac_valid;

    always #2.5 clk = ~clk;

    iq_dac_formatter #(.DATA_W(W)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_interleave (cfg_interleave),
        .cfg_dec2       (cfg_dec2),
        .cfg_offset_bin (cfg_offset_bin),
        .cfg_test_mode  (cfg_test_mode),
        .in_valid       (in_valid),
        .in_sync        (in_sync),
        .in_i           (in_i),
        .in_q           (in_q),
        .dac_a          (dac_a),
        .dac_b          (dac_b),
        .dac_frame      (dac_frame),
        .dac_valid      (dac_valid)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // expected output per cycle slot
    logic [W-1:0] ea [16];
    logic [W-1:0] eb [16];
    logic         ef [16];
    logic         ev [16];
    string        et [16];

    // reference state
    bit           m_phase = 0;
    bit           m_tog = 0;
    logic [W-1:0] m_cnt = '0;

    function automatic logic [W-1:0] to_offset(input logic [W-1:0] x, input bit en);
        return en ? {~x[W-1], x[W-2:0]} : x;
    endfunction

    function automatic bit is_pattern_mode(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    task automatic check_out(input string tag, input logic [W-1:0] xa, input logic [W-1:0] xb,
                             input logic xf, input logic xv);
        checks++;
        if (dac_a !== xa || dac_b !== xb || dac_frame !== xf || dac_valid !== xv) begin
            errors++;
            $display("FAIL %s cyc %0d: got a=%h b=%h f=%b v=%b, expected a=%h b=%h f=%b v=%b",
                     tag, cyc, dac_a, dac_b, dac_frame, dac_valid, xa, xb, xf, xv);
        end
    endtask

    task automatic step(input bit v, input logic [W-1:0] i, input logic [W-1:0] q,
                        input bit s, input string tag);
        int idx;
        bit eff;
        bit keep;
        bit bt;
        logic [W-1:0] bc;
        logic [W-1:0] si, sq, pw;
        @(negedge clk);
        idx = cyc % 16;
        check_out(et[idx], ea[idx], eb[idx], ef[idx], ev[idx]);
        ea[idx] = '0; eb[idx] = '0; ef[idx] = 1'b0; ev[idx] = 1'b0; et[idx] = "R4";
        in_valid = v; in_i = i; in_q = q; in_sync = s;
        // decimation model
        eff  = s ? 1'b0 : m_phase;
        keep = v && (!cfg_dec2 || !eff);
        if (v) m_phase = ~eff; else m_phase = eff;
        // pattern model
        pw = '0;
        if (cfg_test_mode == 2'b01) begin
            bt = s ? 1'b0 : m_tog;
            pw = bt ? '0 : '1;
            m_tog = keep ? ~bt : bt;
        end else m_tog = 0;
        if (cfg_test_mode == 2'b10) begin
            bc = s ? '0 : m_cnt;
            pw = bc;
            m_cnt = keep ? bc + 1'b1 : bc;
        end else m_cnt = '0;
        if (is_pattern_mode(cfg_test_mode)) begin
            si = pw; sq = pw;
        end else begin
            si = to_offset(i, cfg_offset_bin);
            sq = to_offset(q, cfg_offset_bin);
        end
        if (keep) begin
            if (cfg_interleave) begin
                ea[(cyc+2)%16] = si; eb[(cyc+2)%16] = '0; ef[(cyc+2)%16] = 1'b1;
                ev[(cyc+2)%16] = 1'b1; et[(cyc+2)%16] = tag;
                ea[(cyc+3)%16] = sq; eb[(cyc+3)%16] = '0; ef[(cyc+3)%16] = 1'b0;
                ev[(cyc+3)%16] = 1'b1; et[(cyc+3)%16] = tag;
            end else begin
                ea[(cyc+2)%16] = si; eb[(cyc+2)%16] = sq; ef[(cyc+2)%16] = 1'b0;
                ev[(cyc+2)%16] = 1'b1; et[(cyc+2)%16] = tag;
            end
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, '0, '0, 1'b0, "R4");
    endtask

    task automatic set_cfg(input bit il, input bit d2, input bit ob, input logic [1:0] tm);
        idle(4);
        cfg_interleave = il; cfg_dec2 = d2; cfg_offset_bin = ob; cfg_test_mode = tm;
    endtask

    // random run; interleave forces at least one gap between valid samples
    task automatic run_random(input int n, input int pct_valid, input int sync_den, input string tag);
        bit last_v = 0;
        for (int k = 0; k < n; k++) begin
            bit v;
            bit s;
            v = (($urandom % 100) < pct_valid);
            if (cfg_interleave && last_v) v = 0;
            s = (sync_den > 0) ? (($urandom % sync_den) == 0) : 1'b0;
            step(v, W'($urandom), W'($urandom), s, tag);
            last_v = v;
        end
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin
            ea[k] = '0; eb[k] = '0; ef[k] = 1'b0; ev[k] = 1'b0; et[k] = "R1";
        end
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        check_out("R1", '0, '0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;

        // R1/R2/R11: parallel pass-through, then random valid pattern
        step(1'b1, 8'h12, 8'h34, 1'b0, "R2");
        step(1'b1, 8'h80, 8'h7f, 1'b0, "R11");
        step(1'b0, 8'hff, 8'hff, 1'b0, "R4");
        run_random(200, 70, 0, "R2");
        run_random(100, 100, 0, "R11");

        // R7: offset binary in data mode
        set_cfg(1'b0, 1'b0, 1'b1, 2'b00);
        step(1'b1, 8'h00, 8'h80, 1'b0, "R7");
        step(1'b1, 8'h7f, 8'hff, 1'b0, "R7");
        run_random(150, 60, 0, "R7");

        // R3: interleaved format
        set_cfg(1'b1, 1'b0, 1'b0, 2'b00);
        step(1'b1, 8'haa, 8'h55, 1'b0, "R3");
        step(1'b0, '0, '0, 1'b0, "R3");
        step(1'b1, 8'h01, 8'hfe, 1'b0, "R3");
        run_random(250, 60, 0, "R3");

        // R5/R6: half-rate with syncs, parallel
        set_cfg(1'b0, 1'b1, 1'b0, 2'b00);
        step(1'b1, 8'h10, 8'h11, 1'b1, "R6");
        step(1'b1, 8'h20, 8'h21, 1'b0, "R5");
        step(1'b1, 8'h30, 8'h31, 1'b0, "R5");
        step(1'b0, 8'h00, 8'h00, 1'b1, "R6");
        step(1'b1, 8'h40, 8'h41, 1'b0, "R6");
        step(1'b1, 8'h50, 8'h51, 1'b1, "R6");
        run_random(300, 70, 12, "R5");

        // R5 + R3: half-rate in interleaved format
        set_cfg(1'b1, 1'b1, 1'b0, 2'b00);
        run_random(200, 60, 16, "R5");

        // R8/R10: toggle pattern, offset enabled and data random
        set_cfg(1'b0, 1'b0, 1'b1, 2'b01);
        for (int k = 0; k < 6; k++) step(1'b1, 8'h5a, 8'ha5, 1'b0, "R8");
        step(1'b1, 8'h00, 8'h00, 1'b1, "R8");
        run_random(150, 70, 20, "R10");
        set_cfg(1'b1, 1'b1, 1'b0, 2'b01);
        run_random(120, 60, 15, "R8");

        // R9: ramp with wrap, mid-run syncs
        set_cfg(1'b0, 1'b0, 1'b0, 2'b10);
        for (int k = 0; k < 300; k++) step(1'b1, W'($urandom), W'($urandom), 1'b0, "R9");
        step(1'b0, '0, '0, 1'b1, "R9");
        step(1'b1, 8'h33, 8'h44, 1'b0, "R9");
        step(1'b1, 8'h33, 8'h44, 1'b1, "R9");
        run_random(150, 60, 25, "R10");
        set_cfg(1'b1, 1'b1, 1'b1, 2'b10);
        run_random(150, 60, 0, "R9");

        // R10: code 11 passes data
        set_cfg(1'b0, 1'b0, 1'b1, 2'b11);
        step(1'b1, 8'h01, 8'h81, 1'b0, "R10");
        run_random(100, 60, 0, "R10");
        idle(6);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule